// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns a pointer event (a signed horizontal delta, a signed vertical delta and three button levels, qualified by a one-cycle strobe) into a fixed five-byte packet. It writes the packet into a small circular byte queue, and a host drains that queue one byte per read strobe. The packet carries an active-low button header, the horizontal motion, the inverted vertical motion, and two trailing zero motion bytes. Each motion byte is clamped symmetrically so that it always fits in a signed byte.

The encoder writes one byte per clock. It accepts a new event only when it is idle and the queue has room for a whole packet, so a packet never reaches the host in part. A level output tells the host that at least one byte is waiting.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset the queue is empty, `data_avail` and `busy` are low, `rd_data` is 0x00 and `evt_ready` is high.
- R2: An accepted event raises `busy` on the next clock. It then writes exactly five bytes, one per clock, in the order header, X, Y, 0x00, 0x00, and `busy` falls after the fifth write.
- R3: The header byte is 0x87 with bit 2 cleared when left is pressed, bit 1 cleared when middle is pressed and bit 0 cleared when right is pressed.
- R4: The X byte is the input X delta clamped to the range -127..+127, in 8-bit two's complement.
- R5: The Y byte is the negated input Y delta, clamped to -127..+127, in 8-bit two's complement.
- R6: `evt_ready` is high only while `busy` is low and at least five queue entries are free. A strobe while `evt_ready` is low is dropped whole, the queue contents do not change, and the queue never holds more than DEPTH bytes.
- R7: A read strobe on an empty queue makes `rd_data` 0x00 and leaves both pointers where they were, so the next packet is read back in its proper order.
- R8: The read and write pointers wrap to entry 0 after entry DEPTH-1, and byte order is kept across the wrap.
- R9: `data_avail` stays high after a pop while bytes remain and goes low once the last byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle strobe marking a pointer event |
| evt_dx | input | DELTA_W | Signed horizontal delta |
| evt_dy | input | DELTA_W | Signed vertical delta |
| btn_left | input | 1 | Left button level, 1 = pressed |
| btn_mid | input | 1 | Middle button level, 1 = pressed |
| btn_right | input | 1 | Right button level, 1 = pressed |
| evt_ready | output | 1 | An event strobed now would be accepted |
| busy | output | 1 | A packet is still being written to the queue |
| rd_en | input | 1 | Host read strobe, pops one byte |
| rd_data | output | 8 | Byte popped by the most recent read strobe |
| data_avail | output | 1 | The queue holds at least one byte |

## Verification
The hardest case to reach from the ports is a full queue that refuses a packet. The admission check normally keeps the queue from filling, so the bench sends three back-to-back packets without reading, which leaves fewer than five free entries. A fourth strobe must then be refused, and draining exactly fifteen bytes followed by a low `data_avail` shows that nothing from the refused strobe got in. Pointer wrap is reached by moving more than DEPTH bytes through the queue with the table of vectors, and clamping is covered by deltas at both extremes of the input range, including the most negative value, whose negation cannot be represented at the input width.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
   localparam int BYTE_W  = 8;
   localparam int PKT_LEN = 5;
   localparam logic [BYTE_W-1:0] HDR_IDLE = 8'h87;
   localparam int SAT_LIM = 127;
   typedef logic [BYTE_W-1:0] pkt_byte_t;
endpackage

// File: rtl/mpe_sat.sv
module mpe_sat
   import mpe_pkg::*;
#(
   parameter int IN_W = 11
) (
   input  logic signed [IN_W-1:0] val_i,
   output pkt_byte_t              byte_o
);
   localparam logic signed [IN_W-1:0] HI = IN_W'(SAT_LIM);
   localparam logic signed [IN_W-1:0] LO = -IN_W'(SAT_LIM);

   if (IN_W < 9) begin : g_bad_width
      $error("mpe_sat: IN_W must be at least 9");
   end

   always_comb begin
      if (val_i > HI)      byte_o = 8'h7F;
      else if (val_i < LO) byte_o = 8'h81;
      else                 byte_o = val_i[BYTE_W-1:0];
   end
endmodule

// File: rtl/mpe_packer.sv
module mpe_packer
   import mpe_pkg::*;
#(
   parameter int DELTA_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [2:0]         btn_i,
   input  logic [DELTA_W-1:0] dx_i,
   input  logic [DELTA_W-1:0] dy_i,
   output logic               push_o,
   output pkt_byte_t          byte_o,
   output logic               busy_o
);
   localparam int EW = DELTA_W + 1;
   localparam int IW = $clog2(PKT_LEN);
   localparam logic [IW-1:0] LAST = IW'(PKT_LEN - 1);

   logic signed [EW-1:0] dx_ext, dy_neg;
   pkt_byte_t hdr_c, x_c, y_c;
   pkt_byte_t hdr_q, x_q, y_q;
   logic [IW-1:0] idx_q;

   assign dx_ext = $signed({dx_i[DELTA_W-1], dx_i});
   assign dy_neg = -$signed({dy_i[DELTA_W-1], dy_i});
   assign hdr_c  = HDR_IDLE ^ {5'b0, btn_i};

   mpe_sat #(.IN_W(EW)) u_sat_x (.val_i(dx_ext), .byte_o(x_c));
   mpe_sat #(.IN_W(EW)) u_sat_y (.val_i(dy_neg), .byte_o(y_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q  <= '0;
         x_q    <= '0;
         y_q    <= '0;
         idx_q  <= '0;
         busy_o <= 1'b0;
      end else if (start_i && !busy_o) begin
         hdr_q  <= hdr_c;
         x_q    <= x_c;
         y_q    <= y_c;
         idx_q  <= '0;
         busy_o <= 1'b1;
      end else if (busy_o) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST) busy_o <= 1'b0;
      end
   end

   always_comb begin
      unique case (idx_q)
         IW'(0):  byte_o = hdr_q;
         IW'(1):  byte_o = x_q;
         IW'(2):  byte_o = y_q;
         default: byte_o = '0;
      endcase
   end
   assign push_o = busy_o;

   // R2: an accepted event starts at byte 0 on the next clock
   p_start_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && idx_q == '0));
   // R2: the packet ends after the fifth byte
   p_pkt_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && idx_q == LAST) |=> !busy_o);
   // R6: the top never starts a packet while one is in flight
   p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo
   import mpe_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  pkt_byte_t                  din_i,
   input  logic                       pop_i,
   output pkt_byte_t                  dout_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << PW));

   pkt_byte_t mem [DEPTH];
   logic [PW-1:0] rptr_q, wptr_q, rptr_inc, wptr_inc;
   logic full, empty, do_push, do_pop;

   assign full    = (count_o == CW'(DEPTH));
   assign empty   = (count_o == '0);
   assign do_push = push_i && !full;
   assign do_pop  = pop_i && !empty;

   if (POW2) begin : g_wrap_pow2
      assign rptr_inc = rptr_q + 1'b1;
      assign wptr_inc = wptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign rptr_inc = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      assign wptr_inc = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         wptr_q  <= '0;
         count_o <= '0;
         dout_o  <= '0;
      end else begin
         if (do_push) wptr_q <= wptr_inc;
         if (do_pop)  rptr_q <= rptr_inc;
         if (pop_i)   dout_o <= empty ? '0 : mem[rptr_q];
         if (do_push && !do_pop)      count_o <= count_o + 1'b1;
         else if (do_pop && !do_push) count_o <= count_o - 1'b1;
      end
   end

   // R6: occupancy never passes the depth
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(DEPTH));
   // R6: a push into a full queue is dropped
   p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !pop_i) |=> $stable(count_o));
   // R7: an empty pop returns zero and keeps the read pointer
   p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty && !push_i) |=> (rptr_q == $past(rptr_q) && dout_o == '0));
   // R8: pointers wrap from the last entry to zero
   p_rd_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && rptr_q == PW'(DEPTH - 1)) |=> rptr_q == '0);
   p_wr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (do_push && wptr_q == PW'(DEPTH - 1)) |=> wptr_q == '0);
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
   import mpe_pkg::*;
#(
   parameter int DELTA_W = 10,
   parameter int DEPTH   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_valid,
   input  logic [DELTA_W-1:0] evt_dx,
   input  logic [DELTA_W-1:0] evt_dy,
   input  logic               btn_left,
   input  logic               btn_mid,
   input  logic               btn_right,
   output logic               evt_ready,
   output logic               busy,
   input  logic               rd_en,
   output logic [7:0]         rd_data,
   output logic               data_avail
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < PKT_LEN) begin : g_bad_depth
      $error("mouse_pkt_enc: DEPTH must hold one whole packet");
   end
   if (DELTA_W < 8) begin : g_bad_delta
      $error("mouse_pkt_enc: DELTA_W must be at least 8");
   end

   logic [CW-1:0] count;
   logic [CW-1:0] free_ent;
   logic start, push;
   pkt_byte_t push_byte;

   assign free_ent   = CW'(DEPTH) - count;
   assign evt_ready  = !busy && (free_ent >= CW'(PKT_LEN));
   assign start      = evt_valid && evt_ready;
   assign data_avail = (count != '0);

   mpe_packer #(.DELTA_W(DELTA_W)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .btn_i  ({btn_left, btn_mid, btn_right}),
      .dx_i   (evt_dx),
      .dy_i   (evt_dy),
      .push_o (push),
      .byte_o (push_byte),
      .busy_o (busy)
   );

   mpe_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .din_i  (push_byte),
      .pop_i  (rd_en),
      .dout_o (rd_data),
      .count_o(count)
   );

   // R6: an accepted event always finds room for the whole packet
   p_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (count <= CW'(DEPTH - PKT_LEN)));
   // R9: a pop that leaves bytes behind keeps data_avail high
   p_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && count > CW'(1)) |=> data_avail);
endmodule

// File: tb/sim_mouse_pkt_enc.sv
module sim_mouse_pkt_enc;
   localparam int DW = 10;
   localparam int NV = 7;
   // {btn L,M,R, dx, dy, exp hdr, exp x, exp y}
   localparam logic [46:0] VEC [NV] = '{
      {3'b000, 10'h005, 10'h003, 8'h87, 8'h05, 8'hFD},
      {3'b100, 10'h3FB, 10'h3FD, 8'h83, 8'hFB, 8'h03},
      {3'b010, 10'h0C8, 10'h338, 8'h85, 8'h7F, 8'h7F},
      {3'b001, 10'h2D4, 10'h12C, 8'h86, 8'h81, 8'h81},
      {3'b111, 10'h200, 10'h200, 8'h80, 8'h81, 8'h7F},
      {3'b101, 10'h07F, 10'h381, 8'h82, 8'h7F, 8'h7F},
      {3'b110, 10'h381, 10'h080, 8'h81, 8'h81, 8'h81}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic evt_valid = 1'b0, bl = 1'b0, bm = 1'b0, br = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] dx = '0, dy = '0;
   logic evt_ready, busy, data_avail;
   logic [7:0] rd_data;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   mouse_pkt_enc #(.DELTA_W(DW), .DEPTH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(dx), .evt_dy(dy),
      .btn_left(bl), .btn_mid(bm), .btn_right(br), .evt_ready(evt_ready),
      .busy(busy), .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [2:0] b, input logic [DW-1:0] x,
                         input logic [DW-1:0] y, output logic rdy);
      @(negedge clk);
      {bl, bm, br} = b; dx = x; dy = y; evt_valid = 1'b1;
      rdy = evt_ready;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic pop(output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic drain_pkt(input logic [7:0] eh, input logic [7:0] ex,
                            input logic [7:0] ey, input logic last);
      logic [7:0] d;
      pop(d); chk("R3 header", d, eh);
      pop(d); chk("R4 x byte", d, ex);
      pop(d); chk("R5 y byte", d, ey);
      pop(d); chk("R2 zero byte 4", d, 8'h00);
      chk("R9 avail mid-drain", {7'b0, data_avail}, 8'h01);
      pop(d); chk("R2 zero byte 5", d, 8'h00);
      chk("R9 avail after pop", {7'b0, data_avail}, last ? 8'h00 : 8'h01);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic rdy;
      logic [7:0] d;
      repeat (3) @(negedge clk);
      chk("R1 data_avail", {7'b0, data_avail}, 8'h00);
      chk("R1 busy", {7'b0, busy}, 8'h00);
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 evt_ready", {7'b0, evt_ready}, 8'h01);
      rst_n = 1'b1;

      // table walk: 35 bytes through a 16-deep queue, so pointers wrap (R8)
      for (int i = 0; i < NV; i++) begin
         strobe(VEC[i][46:44], VEC[i][43:34], VEC[i][33:24], rdy);
         chk("R6 ready when idle", {7'b0, rdy}, 8'h01);
         chk("R2 busy after accept", {7'b0, busy}, 8'h01);
         repeat (5) @(negedge clk);
         chk("R2 busy done", {7'b0, busy}, 8'h00);
         drain_pkt(VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b1);
      end

      // R7: pop on empty, then order must still be intact
      pop(d);
      chk("R7 empty read data", d, 8'h00);
      chk("R7 empty avail", {7'b0, data_avail}, 8'h00);
      strobe(3'b000, 10'h005, 10'h003, rdy);
      repeat (6) @(negedge clk);
      drain_pkt(8'h87, 8'h05, 8'hFD, 1'b1);

      // R6: strobe while busy is dropped
      strobe(3'b100, 10'h001, 10'h001, rdy);
      {bl, bm, br} = 3'b011; evt_valid = 1'b1;
      chk("R6 not ready while busy", {7'b0, evt_ready}, 8'h00);
      @(negedge clk);
      evt_valid = 1'b0;
      repeat (6) @(negedge clk);
      drain_pkt(8'h83, 8'h01, 8'hFF, 1'b1);

      // R6: three packets fill to 15, a fourth must be refused
      for (int k = 0; k < 3; k++) begin
         strobe(3'b001, 10'(k + 1), 10'h000, rdy);
         chk("R6 ready with room", {7'b0, rdy}, 8'h01);
         repeat (6) @(negedge clk);
      end
      strobe(3'b111, 10'h07F, 10'h07F, rdy);
      chk("R6 refused when short of room", {7'b0, rdy}, 8'h00);
      repeat (6) @(negedge clk);
      for (int k = 0; k < 3; k++)
         drain_pkt(8'h86, 8'(k + 1), 8'h00, k == 2);
      chk("R6 nothing of refused packet", {7'b0, data_avail}, 8'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule